// File: doc/BRIEF.md
# Two-Level Interrupt Status Controller

This block gathers single-cycle event pulses from a storage-card host (card monitor and transfer engine) into a sticky local status register. A local enable mask selects which of those latched bits may raise a request. The masked result feeds one bit of a small global status register. Its other bit is driven by event pulses from a second peripheral that shares the same interrupt line.

The global layer has two independent masks. A status-enable decides whether a source may latch into the global status at all. A signal-enable decides whether a latched global bit reaches the interrupt output. Software clears each layer separately by writing ones to the bits it wants to clear. The registers sit behind a simple word-addressed write port and a registered read port. The single interrupt output is registered.

Register map (word addresses):

| Address | Register | Access |
|---------|----------|--------|
| 0 | local status | write-one-to-clear |
| 1 | local enable | read/write |
| 2 | global status | write-one-to-clear |
| 3 | global status-enable | read/write |
| 4 | global signal-enable | read/write |

Top module: `irq_two_level_ctrl`

## Requirements
- R1: Local status bits exist only at positions 0, 1, 2, 3, 8, 9, 10 and 11 (card detect, status change, memory mode, I/O mode, true-IDE mode, transfer error, buffer available, transfer done). A pulse on any other event line is ignored, and those positions always read 0.
- R2: A pulse on an implemented event line sets its local status bit at the next clock edge, whatever the local enable holds.
- R3: Writing to address 0 clears each local status bit written as 1. Bits written as 0 keep their value.
- R4: When an event pulse and a clearing write hit the same status bit in the same cycle, the bit ends up set. This holds in both the local and the global layer.
- R5: Global status bit 0 sets one cycle after (local status AND local enable) is nonzero, provided global status-enable bit 0 is 1. With status-enable bit 0 at 0, the bit does not set.
- R6: Global status bit 1 sets at the edge after a peer event pulse, provided global status-enable bit 1 is 1. Otherwise the pulse leaves it unchanged.
- R7: Writing ones to address 2 clears the matching global status bits. If the local request for bit 0 is still pending, bit 0 sets again on the following edge.
- R8: `irq` equals, one cycle later, the OR over both global bits of (global status AND signal-enable).
- R9: A read presents the addressed register on `rd_data` at the edge after `rd_en`, zero-extended. Addresses 5 and above read 0. `rd_data` holds its value while `rd_en` is low.
- R10: Under reset every register, `rd_data` and `irq` are 0.
- R11: The local enable stores only the implemented bit positions of R1. The global enables store 2 bits each.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write word address |
| wr_data | input | LOCAL_W | Write data |
| rd_en | input | 1 | Register read strobe |
| rd_addr | input | ADDR_W | Read word address |
| rd_data | output | LOCAL_W | Registered read data |
| card_evt | input | LOCAL_W | Card host event pulses, one per status bit |
| peer_evt | input | GLOBAL_W-1 | Event pulses from the sharing peripheral |
| irq | output | 1 | Registered interrupt line |

## Verification
The bench sends a one-hot pulse on each of the twelve event lines with all enables off. This separates implemented positions from ignored ones, and latching from forwarding. It then changes the mask combinations: local enable, status-enable and signal-enable are each opened alone and then together. This shows which layer gates the latch and which gates the output line. Clearing writes are issued with no event, with a coincident event on the same bit, and while the local source is still pending. These cases tell a plain clear apart from the event-wins rule and from re-latching. Peer pulses with the status-enable closed and then open confirm that the two global sources are independent.

// File: rtl/irq2l_pkg.sv
package irq2l_pkg;
  // Word addresses of the register file
  localparam int unsigned REG_LSTAT = 0;
  localparam int unsigned REG_LEN   = 1;
  localparam int unsigned REG_GSTAT = 2;
  localparam int unsigned REG_GSE   = 3;
  localparam int unsigned REG_GSIG  = 4;

  // Implemented local positions: 0..3 and 8..11
  localparam logic [11:0] DEFAULT_IMPL = 12'hF0F;
endpackage

// File: rtl/irq2l_local_layer.sv
module irq2l_local_layer #(
  parameter int unsigned          LOCAL_W = 12,
  parameter logic [LOCAL_W-1:0]   IMPL    = 12'hF0F
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [LOCAL_W-1:0] evt,
  input  logic               clr_we,
  input  logic               en_we,
  input  logic [LOCAL_W-1:0] wdata,
  output logic [LOCAL_W-1:0] stat_q,
  output logic [LOCAL_W-1:0] en_q,
  output logic               pending
);
  logic [LOCAL_W-1:0] evt_live;
  logic [LOCAL_W-1:0] clr_mask;
  logic [LOCAL_W-1:0] stat_d;

  assign evt_live = evt & IMPL;
  assign clr_mask = clr_we ? wdata : '0;
  // event has priority over a coincident clear
  assign stat_d   = ((stat_q & ~clr_mask) | evt_live) & IMPL;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q <= '0;
      en_q   <= '0;
    end else begin
      stat_q <= stat_d;
      if (en_we) en_q <= wdata & IMPL;
    end
  end

  assign pending = |(stat_q & en_q);
endmodule

// File: rtl/irq2l_global_layer.sv
module irq2l_global_layer #(
  parameter int unsigned GLOBAL_W = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [GLOBAL_W-1:0] src,
  input  logic                clr_we,
  input  logic                sen_we,
  input  logic                sig_we,
  input  logic [GLOBAL_W-1:0] wdata,
  output logic [GLOBAL_W-1:0] gstat_q,
  output logic [GLOBAL_W-1:0] sen_q,
  output logic [GLOBAL_W-1:0] sig_q,
  output logic                irq_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sen_q <= '0;
      sig_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (sen_we) sen_q <= wdata;
      if (sig_we) sig_q <= wdata;
      irq_q <= |(gstat_q & sig_q);
    end
  end

  for (genvar g = 0; g < GLOBAL_W; g++) begin : g_bit
    logic set_req;
    logic clr_req;
    assign set_req = src[g] & sen_q[g];
    assign clr_req = clr_we & wdata[g];
    always_ff @(posedge clk) begin
      if (rst)          gstat_q[g] <= 1'b0;
      else if (set_req) gstat_q[g] <= 1'b1;
      else if (clr_req) gstat_q[g] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq2l_read_mux.sv
module irq2l_read_mux #(
  parameter int unsigned LOCAL_W  = 12,
  parameter int unsigned GLOBAL_W = 2,
  parameter int unsigned ADDR_W   = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   rd_addr,
  input  logic [LOCAL_W-1:0]  lstat,
  input  logic [LOCAL_W-1:0]  len,
  input  logic [GLOBAL_W-1:0] gstat,
  input  logic [GLOBAL_W-1:0] gse,
  input  logic [GLOBAL_W-1:0] gsig,
  output logic [LOCAL_W-1:0]  rd_data
);
  import irq2l_pkg::*;
  localparam int unsigned PADW = LOCAL_W - GLOBAL_W;

  logic [LOCAL_W-1:0] sel;

  always_comb begin
    sel = '0;
    if      (rd_addr == ADDR_W'(REG_LSTAT)) sel = lstat;
    else if (rd_addr == ADDR_W'(REG_LEN))   sel = len;
    else if (rd_addr == ADDR_W'(REG_GSTAT)) sel = {{PADW{1'b0}}, gstat};
    else if (rd_addr == ADDR_W'(REG_GSE))   sel = {{PADW{1'b0}}, gse};
    else if (rd_addr == ADDR_W'(REG_GSIG))  sel = {{PADW{1'b0}}, gsig};
  end

  always_ff @(posedge clk) begin
    if (rst)        rd_data <= '0;
    else if (rd_en) rd_data <= sel;
  end
endmodule

// File: rtl/irq_two_level_ctrl.sv
module irq_two_level_ctrl #(
  parameter int unsigned        LOCAL_W  = 12,
  parameter int unsigned        GLOBAL_W = 2,
  parameter int unsigned        ADDR_W   = 4,
  parameter logic [LOCAL_W-1:0] IMPL     = irq2l_pkg::DEFAULT_IMPL
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [LOCAL_W-1:0]    wr_data,
  input  logic                  rd_en,
  input  logic [ADDR_W-1:0]     rd_addr,
  output logic [LOCAL_W-1:0]    rd_data,
  input  logic [LOCAL_W-1:0]    card_evt,
  input  logic [GLOBAL_W-2:0]   peer_evt,
  output logic                  irq
);
  import irq2l_pkg::*;

  logic                we_lstat, we_len, we_gstat, we_gse, we_gsig;
  logic [LOCAL_W-1:0]  lstat_q, len_q;
  logic [GLOBAL_W-1:0] gstat_q, gse_q, gsig_q;
  logic [GLOBAL_W-1:0] gsrc;
  logic                local_pending;

  assign we_lstat = wr_en && (wr_addr == ADDR_W'(REG_LSTAT));
  assign we_len   = wr_en && (wr_addr == ADDR_W'(REG_LEN));
  assign we_gstat = wr_en && (wr_addr == ADDR_W'(REG_GSTAT));
  assign we_gse   = wr_en && (wr_addr == ADDR_W'(REG_GSE));
  assign we_gsig  = wr_en && (wr_addr == ADDR_W'(REG_GSIG));

  irq2l_local_layer #(.LOCAL_W(LOCAL_W), .IMPL(IMPL)) local_i (
    .clk(clk), .rst(rst), .evt(card_evt),
    .clr_we(we_lstat), .en_we(we_len), .wdata(wr_data),
    .stat_q(lstat_q), .en_q(len_q), .pending(local_pending)
  );

  assign gsrc = {peer_evt, local_pending};

  irq2l_global_layer #(.GLOBAL_W(GLOBAL_W)) global_i (
    .clk(clk), .rst(rst), .src(gsrc),
    .clr_we(we_gstat), .sen_we(we_gse), .sig_we(we_gsig),
    .wdata(wr_data[GLOBAL_W-1:0]),
    .gstat_q(gstat_q), .sen_q(gse_q), .sig_q(gsig_q), .irq_q(irq)
  );

  irq2l_read_mux #(.LOCAL_W(LOCAL_W), .GLOBAL_W(GLOBAL_W), .ADDR_W(ADDR_W)) rmux_i (
    .clk(clk), .rst(rst), .rd_en(rd_en), .rd_addr(rd_addr),
    .lstat(lstat_q), .len(len_q), .gstat(gstat_q), .gse(gse_q), .gsig(gsig_q),
    .rd_data(rd_data)
  );
endmodule

// File: rtl/irq_two_level_ctrl_chk.sv
module irq_two_level_ctrl_chk #(
  parameter int unsigned        LOCAL_W  = 12,
  parameter int unsigned        GLOBAL_W = 2,
  parameter int unsigned        ADDR_W   = 4,
  parameter logic [LOCAL_W-1:0] IMPL     = 12'hF0F
) (
  input logic                clk,
  input logic                rst,
  input logic                wr_en,
  input logic [ADDR_W-1:0]   wr_addr,
  input logic [LOCAL_W-1:0]  wr_data,
  input logic [LOCAL_W-1:0]  card_evt,
  input logic [GLOBAL_W-2:0] peer_evt,
  input logic                irq,
  input logic [LOCAL_W-1:0]  lstat,
  input logic [LOCAL_W-1:0]  len,
  input logic [GLOBAL_W-1:0] gstat,
  input logic [GLOBAL_W-1:0] gse,
  input logic [GLOBAL_W-1:0] gsig
);
  // R2 / R4: an implemented event always lands in local status
  assert_evt_sets_R2: assert property (@(posedge clk) disable iff (rst)
    (|(card_evt & IMPL)) |=> ((lstat & $past(card_evt & IMPL)) == $past(card_evt & IMPL)));

  // R3: written ones without a coincident event are cleared
  assert_w1c_local_R3: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_addr == ADDR_W'(0)) |=> ((lstat & $past(wr_data & ~card_evt)) == '0));

  // R5: masked local request latches into global bit 0
  assert_card_to_global_R5: assert property (@(posedge clk) disable iff (rst)
    ((|(lstat & len)) && gse[0]) |=> gstat[0]);

  // R6: peer pulse latches into global bit 1
  assert_peer_to_global_R6: assert property (@(posedge clk) disable iff (rst)
    (peer_evt[0] && gse[1]) |=> gstat[1]);

  // R8: interrupt line follows masked global status one cycle later
  assert_irq_follow_R8: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq == $past(|(gstat & gsig))));

  // R10: reset clears outputs and status
  assert_reset_clear_R10: assert property (@(posedge clk)
    rst |=> (irq == 1'b0 && lstat == '0 && gstat == '0));
endmodule

bind irq_two_level_ctrl irq_two_level_ctrl_chk #(
  .LOCAL_W(LOCAL_W), .GLOBAL_W(GLOBAL_W), .ADDR_W(ADDR_W), .IMPL(IMPL)
) chk_i (
  .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
  .card_evt(card_evt), .peer_evt(peer_evt), .irq(irq),
  .lstat(lstat_q), .len(len_q), .gstat(gstat_q), .gse(gse_q), .gsig(gsig_q)
);

// File: tb/irq_two_level_ctrl_tb_top.sv
module irq_two_level_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [11:0] wr_data = '0;
  logic        rd_en = 1'b0;
  logic [3:0]  rd_addr = '0;
  logic [11:0] rd_data;
  logic [11:0] card_evt = '0;
  logic [0:0]  peer_evt = '0;
  logic        irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;
  string cur_req = "R10";

  always #4 clk = ~clk;

  irq_two_level_ctrl dut_i (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
    .card_evt(card_evt), .peer_evt(peer_evt), .irq(irq)
  );

  // Behavioural reference model
  logic [11:0] m_l, m_le, m_rd;
  logic [1:0]  m_g, m_gse, m_gsig;
  logic        m_irq;

  function automatic logic [11:0] m_reg(input logic [3:0] a);
    case (a)
      4'd0: return m_l;
      4'd1: return m_le;
      4'd2: return {10'd0, m_g};
      4'd3: return {10'd0, m_gse};
      4'd4: return {10'd0, m_gsig};
      default: return 12'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [11:0] lclr, n_l, n_le, n_rd;
    logic [1:0]  gclr, n_g, n_gse, n_gsig;
    logic        n_irq;
    if (rst) begin
      m_l = 0; m_le = 0; m_rd = 0; m_g = 0; m_gse = 0; m_gsig = 0; m_irq = 0;
    end else begin
      lclr   = (wr_en && wr_addr == 0) ? wr_data : 12'd0;
      gclr   = (wr_en && wr_addr == 2) ? wr_data[1:0] : 2'd0;
      n_l    = ((m_l & ~lclr) | card_evt) & 12'hF0F;
      n_le   = (wr_en && wr_addr == 1) ? (wr_data & 12'hF0F) : m_le;
      n_gse  = (wr_en && wr_addr == 3) ? wr_data[1:0] : m_gse;
      n_gsig = (wr_en && wr_addr == 4) ? wr_data[1:0] : m_gsig;
      n_g[0] = (m_g[0] && !gclr[0]) || (((m_l & m_le) != 0) && m_gse[0]);
      n_g[1] = (m_g[1] && !gclr[1]) || (peer_evt[0] && m_gse[1]);
      n_irq  = |(m_g & m_gsig);
      n_rd   = rd_en ? m_reg(rd_addr) : m_rd;
      m_l = n_l; m_le = n_le; m_gse = n_gse; m_gsig = n_gsig;
      m_g = n_g; m_irq = n_irq; m_rd = n_rd;
    end
  end

  task automatic check(input string req, input logic [11:0] act, input logic [11:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h t=%0t", req, act, exp, $time);
    end
  endtask

  // compare against the model on every clock, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check({cur_req, " irq"}, {11'd0, irq}, {11'd0, m_irq});
      check({cur_req, " rd_data"}, rd_data, m_rd);
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(input logic [3:0] a, input logic [11:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; tick(); wr_en = 0; wr_data = 0;
  endtask

  task automatic rd(input logic [3:0] a);
    rd_en = 1; rd_addr = a; tick(); rd_en = 0;
  endtask

  task automatic pulse(input logic [11:0] ev, input logic pe);
    card_evt = ev; peer_evt[0] = pe; tick(); card_evt = 0; peer_evt[0] = 0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(8 * 20000);
    failures++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    // R10: reset state
    cur_req = "R10";
    for (int a = 0; a < 5; a++) begin
      rd(4'(a));
      check("R10 reset register", rd_data, 12'd0);
    end
    check("R10 irq low", {11'd0, irq}, 12'd0);

    // R1 / R2: each line pulsed with every enable closed
    cur_req = "R1";
    for (int i = 0; i < 12; i++) pulse(12'(1 << i), 1'b0);
    tick();
    rd(0);
    check("R1 implemented positions", rd_data, 12'hF0F);
    cur_req = "R3";
    wr(0, 12'hFFF);
    rd(0);
    check("R3 clear all", rd_data, 12'h000);

    // R2: latch regardless of local enable, nothing forwarded
    cur_req = "R2";
    wr(3, 12'h3);
    pulse(12'h200, 1'b0);
    repeat (3) tick();
    rd(0);
    check("R2 latched while disabled", rd_data, 12'h200);
    rd(2);
    check("R2 no global without enable", rd_data, 12'h000);

    // R11: local enable storage
    cur_req = "R11";
    wr(1, 12'hFFF);
    rd(1);
    check("R11 local enable storage", rd_data, 12'hF0F);
    wr(4, 12'hFFD);
    rd(4);
    check("R11 signal enable storage", rd_data, 12'h001);

    // R5 / R8: pending request climbs to irq
    cur_req = "R5";
    tick();
    rd(2);
    check("R5 global card bit", rd_data, 12'h001);
    cur_req = "R8";
    tick();
    check("R8 irq asserted", {11'd0, irq}, 12'd1);

    // R7: global clear while local still pending re-latches
    cur_req = "R7";
    wr(2, 12'h1);
    rd(2);
    check("R7 relatch", rd_data, 12'h001);
    // R3: partial local clear
    cur_req = "R3";
    pulse(12'h00C, 1'b0);
    wr(0, 12'h204);
    rd(0);
    check("R3 partial clear", rd_data, 12'h008);
    wr(1, 12'h000);
    wr(0, 12'hFFF);
    wr(2, 12'h3);
    tick();
    rd(2);
    check("R7 global cleared", rd_data, 12'h000);
    repeat (2) tick();
    check("R8 irq dropped", {11'd0, irq}, 12'd0);

    // R4: event and clear together, both layers
    cur_req = "R4";
    wr_en = 1; wr_addr = 0; wr_data = 12'h001; card_evt = 12'h001;
    tick();
    wr_en = 0; card_evt = 0;
    rd(0);
    check("R4 local event wins", rd_data, 12'h001);
    wr(0, 12'hFFF);
    wr_en = 1; wr_addr = 2; wr_data = 12'h002; peer_evt[0] = 1;
    tick();
    wr_en = 0; peer_evt[0] = 0;
    rd(2);
    check("R4 global event wins", rd_data, 12'h002);

    // R6: peer gated by status enable, output by signal enable
    cur_req = "R6";
    wr(2, 12'h3);
    wr(3, 12'h1);
    pulse(12'h000, 1'b1);
    rd(2);
    check("R6 peer blocked", rd_data, 12'h000);
    wr(3, 12'h2);
    wr(4, 12'h2);
    pulse(12'h000, 1'b1);
    rd(2);
    check("R6 peer latched", rd_data, 12'h002);
    tick();
    check("R8 irq from peer", {11'd0, irq}, 12'd1);

    // R9: unmapped address and hold behaviour
    cur_req = "R9";
    rd(7);
    check("R9 unmapped", rd_data, 12'h000);
    rd(3);
    repeat (2) tick();
    check("R9 hold", rd_data, 12'h002);

    repeat (3) tick();
    finish_run();
  end
endmodule